// File: doc/BRIEF.md
# Pausable 64-bit Timebase with Coherent Split-Word Access

This block keeps a 64-bit time count that goes up by one on every cycle in which the single-cycle `tick` input is high. Software reaches it through a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and registered read data. The full 64-bit value is wider than one bus word. Both directions of access therefore go through holding registers, so that a two-word transfer sees or sets one consistent 64-bit value.

To load the count, software writes the low word first, which is only staged. It then writes the high word, which commits both halves in one cycle. To read the count, software reads the latched low word first. That access also freezes the upper half into a capture register, which the latched high-word read returns. Two raw read addresses return the live halves and touch no holding register. Counting stops while a software pause bit is set. It also stops while any debug-halt input is asserted whose per-port enable bit is set.

Top module: `timebase64`

## Requirements
- R1: After synchronous reset the count, the staged low word and the captured high word are 0, the pause bit is 0, both debug-halt enables are 1, and the read data is 0.
- R2: When no high-word commit is under way, the count rises by exactly 1 on each cycle where `tick` is 1 and counting is not halted, and holds on every other cycle.
- R3: A write to offset 0x04 only stages the data as the low half; the count is unchanged by it, as a later raw read shows.
- R4: A write to offset 0x00 sets the count in one cycle to {write data, staged low half}; a tick in that same cycle is dropped.
- R5: A read of offset 0x0C returns count bits 31:0 and captures count bits 63:32 on the same access; a later read of offset 0x08 returns the captured value, even if the count has moved on.
- R6: Reads of offset 0x24 and 0x28 return the live count bits 63:32 and 31:0, and leave the captured high word unchanged.
- R7: Bit 0 of offset 0x30 is a read/write pause bit; while it is 1 the count does not advance.
- R8: Bits 1:0 of offset 0x2C are read/write enables, one per debug port; while `dbg_halt[i]` and enable bit i are both 1, the count does not advance.
- R9: The count wraps from all ones to 0 on an accepted tick.
- R10: Read data is registered: it shows the addressed value in the cycle after the read strobe, and it is 0 after a cycle with no read strobe or an unmapped or write-only address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable |
| dbg_halt | input | NDBG | Debug-halt requests, one per port |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
A wrong count shows on the very next raw read, one cycle after the strobe. It keeps showing from then on, because the bench tracks every tick, halt and commit. A wrong staged low word shows up only at the next high-word commit, and only through a later raw or latched read. A wrong captured high word stays hidden until the read of offset 0x08 that follows. Random mixes of ticks, halts and accesses are therefore interleaved with directed read pairs that straddle a carry out of the low half, and with a commit that falls in a tick cycle.

// File: rtl/timebase64_pkg.sv
package timebase64_pkg;
  // Register offsets; low/high pairing order is behaviour, the rest is layout
  localparam logic [7:0] OFF_WR_HI  = 8'h00;
  localparam logic [7:0] OFF_WR_LO  = 8'h04;
  localparam logic [7:0] OFF_RD_HI  = 8'h08;
  localparam logic [7:0] OFF_RD_LO  = 8'h0C;
  localparam logic [7:0] OFF_RAW_HI = 8'h24;
  localparam logic [7:0] OFF_RAW_LO = 8'h28;
  localparam logic [7:0] OFF_DBG_EN = 8'h2C;
  localparam logic [7:0] OFF_PAUSE  = 8'h30;
endpackage

// File: rtl/timebase64_count.sv
module timebase64_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  // Commit wins over a same-cycle tick; natural wrap at all ones
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (tick && !halt) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/timebase64_regs.sv
module timebase64_regs
  import timebase64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NDBG   = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NDBG-1:0]   dbg_halt,
  output logic [DATA_W-1:0] lo_hold,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              pause_q,
  output logic [NDBG-1:0]   dbg_en_q,
  output logic              halt
);
  logic wr_lo, wr_pause, wr_dbg;
  logic [NDBG-1:0] dbg_gated;

  assign load     = bus_wr && (bus_addr == ADDR_W'(OFF_WR_HI));
  assign wr_lo    = bus_wr && (bus_addr == ADDR_W'(OFF_WR_LO));
  assign wr_pause = bus_wr && (bus_addr == ADDR_W'(OFF_PAUSE));
  assign wr_dbg   = bus_wr && (bus_addr == ADDR_W'(OFF_DBG_EN));
  assign load_val = {bus_wdata, lo_hold};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold  <= '0;
      pause_q  <= 1'b0;
      dbg_en_q <= '1;
    end else begin
      if (wr_lo)    lo_hold  <= bus_wdata;
      if (wr_pause) pause_q  <= bus_wdata[0];
      if (wr_dbg)   dbg_en_q <= bus_wdata[NDBG-1:0];
    end
  end

  // Per-port halt gating
  for (genvar i = 0; i < NDBG; i++) begin : g_dbg
    assign dbg_gated[i] = dbg_en_q[i] & dbg_halt[i];
  end

  assign halt = pause_q | (|dbg_gated);
endmodule

// File: rtl/timebase64_rdport.sv
module timebase64_rdport
  import timebase64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NDBG   = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pause_q,
  input  logic [NDBG-1:0]   dbg_en_q,
  output logic [DATA_W-1:0] hi_hold,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] mux;
  logic              cap;

  assign cap = bus_rd && (bus_addr == ADDR_W'(OFF_RD_LO));

  always_comb begin
    mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_RD_LO):  mux = cnt[DATA_W-1:0];
      ADDR_W'(OFF_RD_HI):  mux = hi_hold;
      ADDR_W'(OFF_RAW_LO): mux = cnt[DATA_W-1:0];
      ADDR_W'(OFF_RAW_HI): mux = cnt[CNT_W-1:DATA_W];
      ADDR_W'(OFF_DBG_EN): mux[NDBG-1:0] = dbg_en_q;
      ADDR_W'(OFF_PAUSE):  mux[0] = pause_q;
      default:             mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_hold   <= '0;
      bus_rdata <= '0;
    end else begin
      if (cap) hi_hold <= cnt[CNT_W-1:DATA_W];
      bus_rdata <= bus_rd ? mux : '0;
    end
  end
endmodule

// File: rtl/timebase64.sv
module timebase64 #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NDBG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NDBG-1:0]   dbg_halt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  load_val;
  logic [DATA_W-1:0] lo_hold;
  logic [DATA_W-1:0] hi_hold;
  logic              load;
  logic              halt;
  logic              pause_q;
  logic [NDBG-1:0]   dbg_en_q;

  timebase64_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NDBG(NDBG)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .dbg_halt(dbg_halt), .lo_hold(lo_hold),
    .load(load), .load_val(load_val), .pause_q(pause_q),
    .dbg_en_q(dbg_en_q), .halt(halt)
  );

  timebase64_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt), .load(load),
    .load_val(load_val), .cnt(cnt_q)
  );

  timebase64_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NDBG(NDBG)) u_rd (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .cnt(cnt_q), .pause_q(pause_q), .dbg_en_q(dbg_en_q),
    .hi_hold(hi_hold), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/timebase64_chk.sv
module timebase64_chk
  import timebase64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NDBG   = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [NDBG-1:0]   dbg_halt,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] lo_hold,
  input logic [DATA_W-1:0] hi_hold,
  input logic              pause_q,
  input logic [NDBG-1:0]   dbg_en_q
);
  logic hi_wr;
  assign hi_wr = bus_wr && (bus_addr == ADDR_W'(OFF_WR_HI));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !pause_q && !(|(dbg_en_q & dbg_halt)) && !hi_wr)
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hi_wr) |=> $stable(cnt_q));

  assert_stage_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_WR_LO)) |=> lo_hold == $past(bus_wdata));

  assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> cnt_q == {$past(bus_wdata), $past(lo_hold)});

  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFF_RD_LO))
      |=> hi_hold == $past(cnt_q[CNT_W-1:DATA_W]));

  assert_rawquiet_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == ADDR_W'(OFF_RAW_HI) || bus_addr == ADDR_W'(OFF_RAW_LO)))
      |=> $stable(hi_hold));

  assert_pause_R7: assert property (@(posedge clk) disable iff (rst)
    (pause_q && !hi_wr) |=> $stable(cnt_q));

  assert_dbg_R8: assert property (@(posedge clk) disable iff (rst)
    ((|(dbg_en_q & dbg_halt)) && !hi_wr) |=> $stable(cnt_q));

  assert_rdzero_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind timebase64 timebase64_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NDBG(NDBG)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .dbg_halt(dbg_halt), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cnt_q(cnt_q), .lo_hold(lo_hold), .hi_hold(hi_hold), .pause_q(pause_q),
  .dbg_en_q(dbg_en_q)
);

// File: tb/tb_timebase64.sv
`timescale 1ns/1ps
module tb_timebase64;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  dbg_halt = 2'b00;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model of the architectural state
  logic [63:0] m_cnt;
  logic [31:0] m_lo, m_hi;
  logic        m_pause;
  logic [1:0]  m_dbg;

  always #2.5 clk = ~clk;

  timebase64 dut (
    .clk(clk), .rst(rst), .tick(tick), .dbg_halt(dbg_halt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic m_halted(input logic [1:0] dh);
    return m_pause | (|(m_dbg & dh));
  endfunction

  // Expected read value; a latched low read captures the upper half
  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h0C: begin m_hi = m_cnt[63:32]; return m_cnt[31:0]; end
      8'h08: return m_hi;
      8'h28: return m_cnt[31:0];
      8'h24: return m_cnt[63:32];
      8'h2C: return {30'h0, m_dbg};
      8'h30: return {31'h0, m_pause};
      default: return 32'h0;
    endcase
  endfunction

  // One bus cycle: drive at negedge, model at posedge, sample at next negedge
  task automatic step(input logic [7:0] a, input logic w, input logic r,
                      input logic [31:0] d, input logic tk, input logic [1:0] dh,
                      input string tag);
    logic [31:0] exp;
    logic        h;
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; tick = tk; dbg_halt = dh;
    @(posedge clk);
    h   = m_halted(dh);
    exp = r ? m_read(a) : 32'h0;
    if (w && a == 8'h00)         m_cnt = {d, m_lo};
    else if (tk && !h)           m_cnt = m_cnt + 64'd1;
    if (w && a == 8'h04) m_lo = d;
    if (w && a == 8'h30) m_pause = d[0];
    if (w && a == 8'h2C) m_dbg = d[1:0];
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; tick = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(a, 1'b0, 1'b1, 32'h0, 1'b0, 2'b00, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(a, 1'b1, 1'b0, d, 1'b0, 2'b00, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 64'h0; m_lo = 32'h0; m_hi = 32'h0; m_pause = 1'b0; m_dbg = 2'b11;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 rdata", bus_rdata, 32'h0);
    rd(8'h28, "R1 raw lo");
    rd(8'h24, "R1 raw hi");
    rd(8'h08, "R1 held hi");
    rd(8'h2C, "R1 dbg en");
    rd(8'h30, "R1 pause");
    // R2: ticks count
    for (int i = 0; i < 5; i++) step(8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 2'b00, "R2 tick");
    rd(8'h28, "R2 after 5 ticks");
    // R10: unmapped and write-only addresses read zero
    rd(8'h04, "R10 write-only");
    rd(8'h14, "R10 unmapped");
    // R3: staging does not move the count
    wr(8'h04, 32'hFFFF_FFFE, "R3 stage");
    rd(8'h28, "R3 count unchanged");
    // R4: commit with a same-cycle tick dropped
    step(8'h00, 1'b1, 1'b0, 32'h0000_0007, 1'b1, 2'b00, "R4 commit");
    rd(8'h28, "R4 lo");
    rd(8'h24, "R4 hi");
    // R5: latched pair across a carry
    rd(8'h0C, "R5 latch lo");
    for (int i = 0; i < 3; i++) step(8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 2'b00, "R5 tick");
    rd(8'h24, "R5 live hi moved");
    rd(8'h08, "R5 captured hi");
    // R6: raw reads leave capture alone
    rd(8'h0C, "R6 latch");
    wr(8'h04, 32'h0, "R6 stage");
    wr(8'h00, 32'h1234_5678, "R6 commit");
    rd(8'h24, "R6 raw hi");
    rd(8'h28, "R6 raw lo");
    rd(8'h08, "R6 held unchanged");
    // R7: pause
    wr(8'h30, 32'h1, "R7 set");
    rd(8'h30, "R7 readback");
    for (int i = 0; i < 4; i++) step(8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 2'b00, "R7 tick");
    rd(8'h28, "R7 held");
    wr(8'h30, 32'h0, "R7 clear");
    // R8: debug halt per port
    for (int i = 0; i < 3; i++) step(8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 2'b10, "R8 tick");
    rd(8'h28, "R8 halted");
    wr(8'h2C, 32'h1, "R8 enable port0 only");
    for (int i = 0; i < 3; i++) step(8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 2'b10, "R8 tick");
    rd(8'h28, "R8 port1 masked");
    rd(8'h2C, "R8 readback");
    // R9: wrap
    wr(8'h04, 32'hFFFF_FFFF, "R9 stage");
    wr(8'h00, 32'hFFFF_FFFF, "R9 commit");
    step(8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 2'b00, "R9 tick");
    rd(8'h24, "R9 hi zero");
    rd(8'h28, "R9 lo zero");
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [7:0] a;
      logic w, r;
      logic [31:0] d;
      op = int'($urandom_range(0, 11));
      d = $urandom;
      w = 1'b0; r = 1'b0; a = 8'h00;
      case (op)
        0: begin a = 8'h04; w = 1'b1; end
        1: begin a = 8'h00; w = 1'b1; d = {$urandom_range(0, 2)} == 0 ? 32'h0 : d; end
        2, 3: begin a = 8'h0C; r = 1'b1; end
        4, 5: begin a = 8'h08; r = 1'b1; end
        6: begin a = 8'h24; r = 1'b1; end
        7: begin a = 8'h28; r = 1'b1; end
        8: begin a = 8'h30; w = ($urandom_range(0, 3) == 0); r = !w; d = {31'h0, d[0] & d[1]}; end
        9: begin a = 8'h2C; w = ($urandom_range(0, 3) == 0); r = !w; end
        default: ;
      endcase
      step(a, w, r, d, $urandom_range(0, 3) != 0,
           ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00, "R10 random");
    end
    rd(8'h28, "R2 final lo");
    rd(8'h24, "R2 final hi");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule